// File: doc/BRIEF.md
# Temperature Sensor Background Poll Scheduler

This block shares a bus host engine with software. While background polling is on, it reads the temperature register of each DIMM temperature sensor that a presence mask marks as fitted. A free-running interval timer sets how often a poll may start. Slots are visited one at a time in a fixed rotation. Each poll is a 16-bit word read. The block keeps a 16-bit reading for each slot, the slot it polled last and the last good reading. Software reads any slot's stored value through a combinational read port.

A poll can be a full read, which sends the register pointer byte before the data read, or a short read, which relies on the pointer the sensor already holds. The short read saves the nine clocks of the pointer byte. In pointer mode the block sends the pointer once per slot and then switches that slot to short reads. When software wants the bus it clears the enable and waits for the grant. Any poll already in flight runs to completion first. A set bus-error flag stops all new polls.

The controller has three states. `ST_IDLE` waits for a start. `ST_ISSUE` drives the one-cycle request to the engine. `ST_WAIT` holds until the engine reports completion. The transitions are:
- `ST_IDLE` to `ST_ISSUE` when a timer expiry finds every start condition met (start).
- `ST_ISSUE` to `ST_WAIT` unconditionally (launch).
- `ST_WAIT` to `ST_IDLE` on `eng_done` (finish).

Top module: `tsp_poll_sched`

## Requirements
- R1: After reset the block is in `ST_IDLE` and its outputs have these values: `eng_req`=0, `poll_busy`=0, `last_slot`=0, `last_word`=0, and every stored slot reading is 0. `sw_grant` is 1 while `poll_en` is 0.
- R2: The interval timer expires once every `rate_val`+1 cycles. While polls finish within that interval, successive `eng_req` pulses are exactly `rate_val`+1 cycles apart.
- R3: A poll starts, with `eng_req` high in the next cycle, only on a timer expiry that finds all of these true: `poll_en`=1, `bus_err`=0, `eng_busy`=0 and the block idle. An expiry that fails any condition is dropped.
- R4: Slots are visited in ascending order. A slot whose `present` bit is 0 is skipped, and the order wraps from slot 7 to slot 0. Each time polling is disabled, the rotation restarts at slot 0.
- R5: Every request addresses `eng_addr` = {4'h3, slot}, that is 0x18 to 0x1F, and presents the temperature register pointer 0x05 on `eng_ptr_reg`.
- R6: With `ptr_sel`=0, every poll is a full read (`eng_ptr`=1).
- R7: With `ptr_sel`=1, a poll is a full read the first time a slot is polled after polling was enabled, and the first time after that slot's previous poll ended in NACK. Otherwise it is a short read (`eng_ptr`=0).
- R8: A poll acknowledged at `eng_done` writes `eng_rdata` into that slot's register and into `last_word`. A NACK (`eng_nack`=1) leaves both unchanged. `last_slot` takes the polled slot in both cases.
- R9: While `bus_err`=1, no poll starts. Once it clears, polling resumes at the next timer expiry.
- R10: When `poll_en` falls during a poll, that poll still runs to `eng_done` and stores its result. `sw_grant` rises only once the block is idle with `poll_en`=0, and no request follows while `sw_grant` is 1.
- R11: With `present`=0, no poll is ever started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| poll_en | input | 1 | Background polling enable |
| ptr_sel | input | 1 | 1: use short reads once a slot's pointer is loaded |
| present | input | 8 | Per-slot sensor presence mask |
| rate_val | input | RATE_W | Timer reload value (interval is value+1 cycles) |
| bus_err | input | 1 | Bus error flag; blocks new polls |
| eng_req | output | 1 | One-cycle poll request to the engine |
| eng_addr | output | 7 | Sensor bus address for the request |
| eng_ptr | output | 1 | 1: full read with pointer byte, 0: short read |
| eng_ptr_reg | output | 8 | Register pointer byte for full reads |
| eng_busy | input | 1 | Engine carrying any transaction |
| eng_done | input | 1 | One-cycle completion of the poll |
| eng_nack | input | 1 | Completion ended in NACK (with eng_done) |
| eng_rdata | input | DATA_W | Word read by the engine (with eng_done) |
| poll_busy | output | 1 | A poll is between start and completion |
| sw_grant | output | 1 | Bus may be used by software |
| last_slot | output | 3 | Slot of the most recently completed poll |
| last_word | output | DATA_W | Most recent acknowledged reading |
| rd_slot | input | 3 | Slot select for the reading port |
| rd_word | output | DATA_W | Stored reading of `rd_slot` |

## Verification
Two pairs of events can fall in the same cycle. First, software can drop `poll_en` while a poll is in flight. The bench clears the enable in the cycle right after a request is seen. It then checks that `sw_grant` stays low until completion, and that the late reading is still stored. Second, a timer expiry can coincide with a busy engine or a set error flag. The bench holds `eng_busy` or `bus_err` high across several expiries and requires that no request appears. After the flag clears, it requires a request within one interval.

// File: rtl/tsp_pkg.sv
package tsp_pkg;
    localparam int SLOT_N = 8;
    localparam int SLOT_W = $clog2(SLOT_N);
    localparam logic [3:0] SENSOR_TYPE = 4'h3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } poll_state_e;
endpackage

// File: rtl/tsp_rate_timer.sv
module tsp_rate_timer #(
    parameter int RATE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] rate_val,
    output logic              tick
);
    logic [RATE_W-1:0] cnt_q;

    // free-running down counter, reloads on zero
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (cnt_q == '0)
            cnt_q <= rate_val;
        else
            cnt_q <= cnt_q - 1'b1;
    end

    assign tick = (cnt_q == '0);
endmodule

// File: rtl/tsp_slot_pick.sv
module tsp_slot_pick #(
    parameter int N = 8,
    localparam int W = $clog2(N)
) (
    input  logic [N-1:0] present,
    input  logic [W-1:0] start,
    output logic         found,
    output logic [W-1:0] pick
);
    logic [2*N-1:0] dbl;
    logic [N-1:0]   rot;
    logic [W-1:0]   off;

    assign dbl = {present, present};
    assign rot = dbl[start +: N];

    // lowest set bit of the rotated mask is the nearest slot at or after start
    always_comb begin
        found = 1'b0;
        off   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (rot[i]) begin
                found = 1'b1;
                off   = W'(i);
            end
        end
        pick = W'((int'(start) + int'(off)) % N);
    end
endmodule

// File: rtl/tsp_reading_bank.sv
module tsp_reading_bank #(
    parameter int N  = 8,
    parameter int DW = 16,
    localparam int W = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [W-1:0]  wslot,
    input  logic [DW-1:0] wdata,
    input  logic [W-1:0]  rslot,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] regs [N];

    for (genvar g = 0; g < N; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (we && wslot == W'(g))
                regs[g] <= wdata;
        end
    end

    assign rdata = regs[rslot];
endmodule

// File: rtl/tsp_poll_sched.sv
module tsp_poll_sched
    import tsp_pkg::*;
#(
    parameter int         RATE_W  = 16,
    parameter int         DATA_W  = 16,
    parameter logic [7:0] PTR_REG = 8'h05
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              poll_en,
    input  logic              ptr_sel,
    input  logic [7:0]        present,
    input  logic [RATE_W-1:0] rate_val,
    input  logic              bus_err,
    output logic              eng_req,
    output logic [6:0]        eng_addr,
    output logic              eng_ptr,
    output logic [7:0]        eng_ptr_reg,
    input  logic              eng_busy,
    input  logic              eng_done,
    input  logic              eng_nack,
    input  logic [DATA_W-1:0] eng_rdata,
    output logic              poll_busy,
    output logic              sw_grant,
    output logic [2:0]        last_slot,
    output logic [DATA_W-1:0] last_word,
    input  logic [2:0]        rd_slot,
    output logic [DATA_W-1:0] rd_word
);
    poll_state_e state_q, state_d;

    logic              tick;
    logic              found;
    logic [SLOT_W-1:0] pick;
    logic [SLOT_W-1:0] next_q;
    logic [SLOT_W-1:0] cur_q;
    logic              full_q;
    logic [SLOT_N-1:0] loaded_q;
    logic              start_ok;
    logic              finish;

    tsp_rate_timer #(.RATE_W(RATE_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .rate_val (rate_val),
        .tick     (tick)
    );

    tsp_slot_pick #(.N(SLOT_N)) u_pick (
        .present (present),
        .start   (next_q),
        .found   (found),
        .pick    (pick)
    );

    assign start_ok = tick && poll_en && !bus_err && !eng_busy && found;
    assign finish   = (state_q == ST_WAIT) && eng_done;

    tsp_reading_bank #(.N(SLOT_N), .DW(DATA_W)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (finish && !eng_nack),
        .wslot (cur_q),
        .wdata (eng_rdata),
        .rslot (rd_slot),
        .rdata (rd_word)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_ok) state_d = ST_ISSUE;
            ST_ISSUE: state_d = ST_WAIT;
            ST_WAIT:  if (eng_done) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        eng_req     = (state_q == ST_ISSUE);
        poll_busy   = (state_q != ST_IDLE);
        sw_grant    = !poll_en && (state_q == ST_IDLE);
        eng_addr    = {SENSOR_TYPE, cur_q};
        eng_ptr     = full_q;
        eng_ptr_reg = PTR_REG;
    end

    // slot rotation and per-slot pointer knowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_q   <= '0;
            cur_q    <= '0;
            full_q   <= 1'b0;
            loaded_q <= '0;
        end else begin
            if (state_q == ST_IDLE && start_ok) begin
                cur_q  <= pick;
                full_q <= !ptr_sel || !loaded_q[pick];
                next_q <= pick + 1'b1;
            end else if (!poll_en && state_q == ST_IDLE) begin
                next_q <= '0;
            end
            if (!poll_en)
                loaded_q <= '0;
            else if (finish)
                loaded_q[cur_q] <= !eng_nack;
        end
    end

    // last poll record
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_slot <= '0;
            last_word <= '0;
        end else if (finish) begin
            last_slot <= cur_q;
            if (!eng_nack)
                last_word <= eng_rdata;
        end
    end
endmodule

// File: rtl/tsp_poll_sched_chk.sv
module tsp_poll_sched_chk #(
    parameter logic [7:0] PTR_REG = 8'h05
) (
    input logic       clk,
    input logic       rst_n,
    input logic       poll_en,
    input logic       ptr_sel,
    input logic [7:0] present,
    input logic       bus_err,
    input logic       eng_busy,
    input logic       eng_done,
    input logic       eng_req,
    input logic [6:0] eng_addr,
    input logic       eng_ptr,
    input logic [7:0] eng_ptr_reg,
    input logic       poll_busy,
    input logic       sw_grant
);
    // R3
    start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req |-> $past(poll_en && !bus_err && !eng_busy));

    // R11
    present_need_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req |-> ($past(present) != 8'h00));

    // R5
    addr_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req |-> (eng_addr[6:3] == 4'h3 && eng_ptr_reg == PTR_REG));

    // R6
    full_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && $past(!ptr_sel)) |-> eng_ptr);

    // R10
    grant_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_grant |=> !eng_req);

    // R10
    inflight_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req |=> poll_busy);

    // R10
    finish_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(poll_busy) |-> $past(eng_done));
endmodule

bind tsp_poll_sched tsp_poll_sched_chk #(.PTR_REG(PTR_REG)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .poll_en     (poll_en),
    .ptr_sel     (ptr_sel),
    .present     (present),
    .bus_err     (bus_err),
    .eng_busy    (eng_busy),
    .eng_done    (eng_done),
    .eng_req     (eng_req),
    .eng_addr    (eng_addr),
    .eng_ptr     (eng_ptr),
    .eng_ptr_reg (eng_ptr_reg),
    .poll_busy   (poll_busy),
    .sw_grant    (sw_grant)
);

// File: tb/tsp_poll_sched_tb.sv
module tsp_poll_sched_tb;
    localparam int RATE_W = 16;
    localparam int DATA_W = 16;

    typedef struct packed {
        logic [7:0]  present;
        logic [7:0]  rate;
        logic        ptr_sel;
        logic [7:0]  nack;
        logic [11:0] slots;   // {s3,s2,s1,s0}
        logic [3:0]  ptrs;    // {p3,p2,p1,p0}
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{8'h01, 8'd20, 1'b0, 8'h00, {3'd0, 3'd0, 3'd0, 3'd0}, 4'b1111},
        '{8'h05, 8'd24, 1'b1, 8'h00, {3'd2, 3'd0, 3'd2, 3'd0}, 4'b0011},
        '{8'h05, 8'd24, 1'b1, 8'h04, {3'd2, 3'd0, 3'd2, 3'd0}, 4'b1011},
        '{8'h92, 8'd30, 1'b1, 8'h00, {3'd1, 3'd7, 3'd4, 3'd1}, 4'b0111},
        '{8'h80, 8'd22, 1'b0, 8'h00, {3'd7, 3'd7, 3'd7, 3'd7}, 4'b1111},
        '{8'hFF, 8'd26, 1'b1, 8'h00, {3'd3, 3'd2, 3'd1, 3'd0}, 4'b1111},
        '{8'h48, 8'd28, 1'b1, 8'h48, {3'd6, 3'd3, 3'd6, 3'd3}, 4'b1111}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              poll_en = 1'b0;
    logic              ptr_sel = 1'b0;
    logic [7:0]        present = 8'h00;
    logic [RATE_W-1:0] rate_val = 16'd20;
    logic              bus_err = 1'b0;
    logic              eng_req;
    logic [6:0]        eng_addr;
    logic              eng_ptr;
    logic [7:0]        eng_ptr_reg;
    logic              eng_busy;
    logic              eng_done = 1'b0;
    logic              eng_nack = 1'b0;
    logic [DATA_W-1:0] eng_rdata = '0;
    logic              poll_busy;
    logic              sw_grant;
    logic [2:0]        last_slot;
    logic [DATA_W-1:0] last_word;
    logic [2:0]        rd_slot = 3'd0;
    logic [DATA_W-1:0] rd_word;

    logic              sw_busy = 1'b0;
    logic              m_busy = 1'b0;
    logic [7:0]        nack_mask = 8'h00;

    always #2.5 clk = ~clk;

    assign eng_busy = m_busy | sw_busy;

    tsp_poll_sched #(.RATE_W(RATE_W), .DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .poll_en(poll_en), .ptr_sel(ptr_sel),
        .present(present), .rate_val(rate_val), .bus_err(bus_err),
        .eng_req(eng_req), .eng_addr(eng_addr), .eng_ptr(eng_ptr),
        .eng_ptr_reg(eng_ptr_reg), .eng_busy(eng_busy), .eng_done(eng_done),
        .eng_nack(eng_nack), .eng_rdata(eng_rdata), .poll_busy(poll_busy),
        .sw_grant(sw_grant), .last_slot(last_slot), .last_word(last_word),
        .rd_slot(rd_slot), .rd_word(rd_word)
    );

    // engine model and request log, acting on the falling edge
    int          cyc = 0;
    int          req_cnt = 0;
    int          addr_bad = 0;
    int          m_cnt = 0;
    logic [2:0]  m_slot = 3'd0;
    logic [15:0] m_data = 16'h0;
    logic [15:0] seed = 16'h1234;
    logic [2:0]  req_slot [64];
    logic        req_ptr  [64];
    int          req_cyc  [64];
    logic [15:0] exp_store [8];
    logic [15:0] exp_word = 16'h0;
    logic [2:0]  exp_slot = 3'd0;

    initial for (int i = 0; i < 8; i++) exp_store[i] = 16'h0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        eng_done <= 1'b0;
        if (!rst_n) begin
            m_cnt  <= 0;
            m_busy <= 1'b0;
        end else if (m_cnt > 0) begin
            m_cnt <= m_cnt - 1;
            if (m_cnt == 1) begin
                eng_done  <= 1'b1;
                eng_nack  <= nack_mask[m_slot];
                eng_rdata <= m_data;
                m_busy    <= 1'b0;
                exp_slot  <= m_slot;
                if (!nack_mask[m_slot]) begin
                    exp_store[m_slot] <= m_data;
                    exp_word          <= m_data;
                end
            end
        end else if (eng_req) begin
            if (eng_addr[6:3] != 4'h3 || eng_ptr_reg != 8'h05)
                addr_bad <= addr_bad + 1;
            req_slot[req_cnt[5:0]] <= eng_addr[2:0];
            req_ptr[req_cnt[5:0]]  <= eng_ptr;
            req_cyc[req_cnt[5:0]]  <= cyc;
            req_cnt <= req_cnt + 1;
            m_busy  <= 1'b1;
            m_cnt   <= eng_ptr ? 13 : 4;
            m_slot  <= eng_addr[2:0];
            m_data  <= seed ^ {13'h0, eng_addr[2:0]};
            seed    <= seed + 16'h0B3D;
        end
    end

    int  n_chk = 0;
    int  n_fail = 0;
    bit  ended = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic release_bus();
        int g;
        poll_en = 1'b0;
        g = 0;
        while (!sw_grant && g < 100) begin step(1); g++; end
        step(2);
    endtask

    task automatic check_store(input string req);
        for (int s = 0; s < 8; s++) begin
            rd_slot = 3'(s);
            #0.5;
            check(rd_word == exp_store[s], req, rd_word, exp_store[s]);
        end
    endtask

    // watchdog
    initial begin
        #(5 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=0x%0h expected=0x%0h", cyc, 0);
        finish_run();
    end

    initial begin
        int base;
        int g;
        step(4);
        rst_n = 1'b1;
        step(1);

        // R1: reset state
        check(eng_req == 1'b0 && poll_busy == 1'b0, "R1 idle", {eng_req, poll_busy}, 0);
        check(last_slot == 3'd0, "R1 last_slot", last_slot, 0);
        check(last_word == 16'h0, "R1 last_word", last_word, 0);
        check(sw_grant == 1'b1, "R1 sw_grant", sw_grant, 1);
        check_store("R1 store");

        // table walk: R2 R4 R5 R6 R7 R8
        for (int v = 0; v < NV; v++) begin
            present   = VECS[v].present;
            rate_val  = RATE_W'(VECS[v].rate);
            ptr_sel   = VECS[v].ptr_sel;
            nack_mask = VECS[v].nack;
            base      = req_cnt;
            poll_en   = 1'b1;
            g = 0;
            while (req_cnt < base + 4 && g < 600) begin step(1); g++; end
            release_bus();
            for (int k = 0; k < 4; k++) begin
                check(req_slot[6'(base + k)] == VECS[v].slots[3*k +: 3], "R4 slot order",
                      req_slot[6'(base + k)], VECS[v].slots[3*k +: 3]);
                check(req_ptr[6'(base + k)] == VECS[v].ptrs[k],
                      VECS[v].ptr_sel ? "R7 short/full" : "R6 full read",
                      req_ptr[6'(base + k)], VECS[v].ptrs[k]);
            end
            for (int k = 1; k < 4; k++)
                check(req_cyc[6'(base + k)] - req_cyc[6'(base + k - 1)] == int'(VECS[v].rate) + 1,
                      "R2 interval", req_cyc[6'(base + k)] - req_cyc[6'(base + k - 1)],
                      int'(VECS[v].rate) + 1);
            check(addr_bad == 0, "R5 address and pointer", addr_bad, 0);
            check(last_slot == VECS[v].slots[9 +: 3], "R8 last_slot", last_slot, VECS[v].slots[9 +: 3]);
            check(last_word == exp_word, "R8 last_word", last_word, exp_word);
            check_store("R8 per-slot store");
        end

        // R11: no slot present
        present = 8'h00; rate_val = 16'd20; ptr_sel = 1'b0; nack_mask = 8'h00;
        base = req_cnt; poll_en = 1'b1;
        step(100);
        check(req_cnt == base, "R11 no present slot", req_cnt - base, 0);
        release_bus();

        // R9: bus error blocks, clearing resumes
        present = 8'h01; bus_err = 1'b1;
        base = req_cnt; poll_en = 1'b1;
        step(100);
        check(req_cnt == base, "R9 halted on error", req_cnt - base, 0);
        bus_err = 1'b0;
        step(24);
        check(req_cnt >= base + 1, "R9 resume", req_cnt - base, 1);
        release_bus();

        // R3: engine busy with software work drops every expiry
        sw_busy = 1'b1;
        base = req_cnt; poll_en = 1'b1;
        step(100);
        check(req_cnt == base, "R3 engine busy", req_cnt - base, 0);
        poll_en = 1'b0;
        step(2);
        sw_busy = 1'b0;
        step(60);
        check(req_cnt == base, "R3 disabled", req_cnt - base, 0);

        // R10: disable during an in-flight poll
        present = 8'h01; ptr_sel = 1'b0;
        base = req_cnt; poll_en = 1'b1;
        g = 0;
        while (req_cnt == base && g < 100) begin step(1); g++; end
        poll_en = 1'b0;
        #0.5;
        check(poll_busy == 1'b1 && sw_grant == 1'b0, "R10 held during poll", {poll_busy, sw_grant}, 2);
        g = 0;
        while (poll_busy && g < 100) begin step(1); g++; end
        check(sw_grant == 1'b1, "R10 grant after finish", sw_grant, 1);
        rd_slot = 3'd0;
        #0.5;
        check(rd_word == exp_store[0], "R10 in-flight stored", rd_word, exp_store[0]);
        base = req_cnt;
        step(60);
        check(req_cnt == base, "R10 quiet after grant", req_cnt - base, 0);

        finish_run();
    end
endmodule